// File: doc/BRIEF.md
# USB Endpoint Interrupt Aggregator

This block gathers the event lines of a USB controller core (per-endpoint transmit events, per-endpoint receive events and core-level bus events) into one 32-bit raw source register. Software reads that register, or a view of it filtered by an enable mask, over a plain 32-bit register bus. Each of the source and the mask has its own write-one-to-set and write-one-to-clear aliases, so software never needs a read-modify-write cycle to change them.

The block drives one level interrupt line to the CPU. When the line fires, the block disarms itself. The line drops once every enabled source has been acknowledged. It cannot fire again until software writes, with any data, to the end-of-interrupt register. Hardware events that arrive in the meantime are still collected and are never lost. A soft-reset bit in a control register returns the whole block to its reset state.

Top module: `usb_irq_agg`

## Requirements
- R1: After reset the raw source (0x20), the mask (0x2C) and the masked view (0x38) all read 0, and `irq_out` is low.
- R2: Bit mapping. Transmit event `evt_tx[i]` sets source bit i (bits 4:0). Receive event `evt_rx[j]` sets source bit 9+j (bits 12:9), and bit 8 stays 0. Core event `evt_core[k]` sets source bit 16+k (bits 24:16). Bit 24 is the VBUS-drive-change event.
- R3: Source bits are sticky. An event pulse of one cycle shows in the source on the next read and stays there until it is cleared.
- R4: Writing to 0x24 sets every source bit whose data bit is 1. Writing to 0x28 clears every such bit. When a hardware event and a clear hit the same bit in one cycle, the bit ends up set.
- R5: The mask at 0x2C takes a direct write. A write to 0x30 sets the mask bits that are 1 in the data, and a write to 0x34 clears them.
- R6: 0x38 reads the raw source ANDed with the mask. A source bit whose mask bit is 0 does not drive `irq_out`.
- R7: While armed, `irq_out` rises on the second clock edge after an enabled event is presented. It falls on the clock edge after the masked source becomes zero.
- R8: After the line has fired, it stays low even with a new enabled source until any write to 0x3C. It then rises on the following edge if an enabled source is pending.
- R9: Writing 1 to bit 0 of 0x04 clears the source and the mask, re-arms the block and drops `irq_out`. Writing 0 to that bit has no effect. 0x04 reads 0.
- R10: Unimplemented source and mask bits (7:5, 8, 15:13, 31:25) read 0 and ignore writes. Undefined offsets read 0.
- R11: Writes to 0x20 and 0x38 leave the source and the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_tx | input | 5 | Transmit endpoint events (endpoint 0 and four more) |
| evt_rx | input | 4 | Receive endpoint events (endpoints 1 to 4) |
| evt_core | input | 9 | Core bus events; bit 8 is VBUS-drive change |
| irq_out | output | 1 | Level interrupt to the CPU |

## Verification
A wrong source bit shows up the next time the source or the masked view is read. It also appears as an early or missing `irq_out` two edges after the event. A corrupted arm state shows in the wrong cycle: the line rises again before the end-of-interrupt write, or stays low after it. The tests therefore sample `irq_out` on every edge around acknowledge and EOI writes. A stuck mask bit shows as a masked-view mismatch, or as an interrupt raised by a source that is disabled.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_RAW     = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_SRC_SET = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_SRC_CLR = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_MASK    = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_MSK_SET = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_MSK_CLR = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_MASKED  = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_EOI     = 8'h3C;

  localparam int RX_BASE   = 8;
  localparam int CORE_BASE = 16;

  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/usb_irq_rst_sync.sv
module usb_irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/usb_irq_bitreg.sv
module usb_irq_bitreg
  import usb_irq_pkg::*;
#(
  parameter word_t IMPL = '1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  soft_clr,
  input  logic  load_en,
  input  word_t load_val,
  input  word_t set_bits,
  input  word_t clr_bits,
  input  word_t hw_bits,
  output word_t q
);
  word_t q_r, d;
  logic  upd;

  always_comb begin
    upd = soft_clr | load_en | (|set_bits) | (|clr_bits) | (|hw_bits);
    if (soft_clr) d = '0;
    else          d = ((((load_en ? load_val : q_r) & ~clr_bits) | set_bits | hw_bits) & IMPL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_r <= '0;
    else if (upd) q_r <= d;
  end

  assign q = q_r;

  a_r10_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (q_r & ~IMPL) == '0);
endmodule

// File: rtl/usb_irq_arm.sv
module usb_irq_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_clr,
  input  logic eoi,
  input  logic pending,
  output logic irq
);
  logic armed_q, armed_d, line_q, line_d;

  always_comb begin
    armed_d = armed_q;
    line_d  = line_q;
    if (soft_clr) begin
      armed_d = 1'b1;
      line_d  = 1'b0;
    end else begin
      if (!pending) line_d = 1'b0;
      if (eoi)      armed_d = 1'b1;
      if (armed_q && pending) begin
        line_d  = 1'b1;
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      line_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      line_q  <= line_d;
    end
  end

  assign irq = line_q;

  a_r8_quiet_until_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !eoi && !soft_clr && !line_q) |=> !line_q);
  a_r7_drop_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending) |=> !line_q);
  a_r7_fire_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_q) |-> !armed_q);
endmodule

// File: rtl/usb_irq_agg.sv
module usb_irq_agg
  import usb_irq_pkg::*;
#(
  parameter int N_TX   = 5,
  parameter int N_RX   = 4,
  parameter int N_CORE = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_TX-1:0]   evt_tx,
  input  logic [N_RX-1:0]   evt_rx,
  input  logic [N_CORE-1:0] evt_core,
  output logic              irq_out
);
  localparam word_t TX_FIELD   = word_t'((64'd1 << N_TX) - 1);
  localparam word_t RX_FIELD   = word_t'(((64'd1 << N_RX) - 1) << (RX_BASE + 1));
  localparam word_t CORE_FIELD = word_t'(((64'd1 << N_CORE) - 1) << CORE_BASE);
  localparam word_t IMPL_BITS  = TX_FIELD | RX_FIELD | CORE_FIELD;

  logic  rst_n_s;
  word_t hw_vec, src_q, mask_q, masked;
  logic  wr_ctrl, wr_sset, wr_sclr, wr_mask, wr_mset, wr_mclr, wr_eoi, soft_clr;

  usb_irq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  always_comb begin
    hw_vec = '0;
    for (int i = 0; i < N_TX; i++)   hw_vec[i]                 = evt_tx[i];
    for (int j = 0; j < N_RX; j++)   hw_vec[RX_BASE + 1 + j]   = evt_rx[j];
    for (int k = 0; k < N_CORE; k++) hw_vec[CORE_BASE + k]     = evt_core[k];
  end

  always_comb begin
    wr_ctrl  = bus_we && (bus_addr == OFS_CTRL);
    wr_sset  = bus_we && (bus_addr == OFS_SRC_SET);
    wr_sclr  = bus_we && (bus_addr == OFS_SRC_CLR);
    wr_mask  = bus_we && (bus_addr == OFS_MASK);
    wr_mset  = bus_we && (bus_addr == OFS_MSK_SET);
    wr_mclr  = bus_we && (bus_addr == OFS_MSK_CLR);
    wr_eoi   = bus_we && (bus_addr == OFS_EOI);
    soft_clr = wr_ctrl && bus_wdata[0];
  end

  usb_irq_bitreg #(.IMPL(IMPL_BITS)) u_src (
    .clk(clk), .rst_n(rst_n_s), .soft_clr(soft_clr),
    .load_en(1'b0), .load_val('0),
    .set_bits(wr_sset ? bus_wdata : '0),
    .clr_bits(wr_sclr ? bus_wdata : '0),
    .hw_bits(hw_vec), .q(src_q)
  );

  usb_irq_bitreg #(.IMPL(IMPL_BITS)) u_mask (
    .clk(clk), .rst_n(rst_n_s), .soft_clr(soft_clr),
    .load_en(wr_mask), .load_val(bus_wdata),
    .set_bits(wr_mset ? bus_wdata : '0),
    .clr_bits(wr_mclr ? bus_wdata : '0),
    .hw_bits('0), .q(mask_q)
  );

  assign masked = src_q & mask_q;

  usb_irq_arm u_arm (
    .clk(clk), .rst_n(rst_n_s), .soft_clr(soft_clr),
    .eoi(wr_eoi), .pending(|masked), .irq(irq_out)
  );

  always_comb begin
    case (bus_addr)
      OFS_RAW:    bus_rdata = src_q;
      OFS_MASK:   bus_rdata = mask_q;
      OFS_MASKED: bus_rdata = masked;
      default:    bus_rdata = '0;
    endcase
  end

  a_r3_tx0_latched: assert property (@(posedge clk) disable iff (!rst_n_s)
    (evt_tx[0] && !soft_clr) |=> src_q[0]);
  a_r4_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n_s)
    (evt_core[N_CORE-1] && wr_sclr && !soft_clr) |=> src_q[CORE_BASE + N_CORE - 1]);
  a_r9_soft_clears: assert property (@(posedge clk) disable iff (!rst_n_s)
    soft_clr |=> (src_q == '0 && mask_q == '0 && !irq_out));
  a_r2_rx_gap_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    !src_q[RX_BASE] && !mask_q[RX_BASE]);
endmodule

// File: tb/usb_irq_agg_test.sv
module usb_irq_agg_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  evt_tx = '0;
  logic [3:0]  evt_rx = '0;
  logic [8:0]  evt_core = '0;
  logic        irq_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_irq_agg uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_tx(evt_tx),
    .evt_rx(evt_rx), .evt_core(evt_core), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic clean();
    wr(8'h04, 32'h1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h20, v); check("R1 raw", v, 0);
    rd(8'h2C, v); check("R1 mask", v, 0);
    rd(8'h38, v); check("R1 masked", v, 0);
    check("R1 irq", {31'b0, irq_out}, 0);
  endtask

  task automatic t_mapping();
    logic [31:0] v;
    @(negedge clk);
    evt_tx = 5'h1F; evt_rx = 4'hF; evt_core = 9'h1FF;
    @(negedge clk);
    evt_tx = '0; evt_rx = '0; evt_core = '0;
    cycles(2);
    rd(8'h20, v); check("R2 R3 full map sticky", v, 32'h01FF1E1F);
    wr(8'h28, 32'hFFFFFFFF);
    @(negedge clk); evt_core = 9'h100; @(negedge clk); evt_core = '0;
    rd(8'h20, v); check("R2 vbus bit24", v, 32'h01000000);
    @(negedge clk); evt_rx = 4'h1; @(negedge clk); evt_rx = '0;
    rd(8'h20, v); check("R3 accumulate", v, 32'h01000200);
    clean();
  endtask

  task automatic t_set_clr();
    logic [31:0] v;
    wr(8'h24, 32'hFFFFFFFF);
    rd(8'h20, v); check("R4 R10 set all", v, 32'h01FF1E1F);
    wr(8'h28, 32'h00000010);
    rd(8'h20, v); check("R4 clear one", v, 32'h01FF1E0F);
    @(negedge clk);
    bus_addr = 8'h28; bus_wdata = 32'h00000001; bus_we = 1'b1; evt_tx = 5'h01;
    @(negedge clk);
    bus_we = 1'b0; evt_tx = '0;
    rd(8'h20, v); check("R4 event beats clear", v & 32'h1, 32'h1);
    clean();
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(8'h2C, 32'hFFFF0103);
    rd(8'h2C, v); check("R5 R10 mask direct", v, 32'h01FF0003);
    wr(8'h2C, 32'h00010003);
    wr(8'h30, 32'h01000000);
    rd(8'h2C, v); check("R5 mask set", v, 32'h01010003);
    wr(8'h34, 32'h00000001);
    rd(8'h2C, v); check("R5 mask clear", v, 32'h01010002);
    wr(8'h24, 32'h01000006);
    rd(8'h38, v); check("R6 masked view", v, 32'h01000002);
    wr(8'h20, 32'hFFFFFFFF);
    wr(8'h38, 32'h00000000);
    rd(8'h20, v); check("R11 raw unchanged", v, 32'h01000006);
    rd(8'h2C, v); check("R11 mask unchanged", v, 32'h01010002);
    clean();
  endtask

  task automatic t_irq();
    wr(8'h2C, 32'h00000002);
    @(negedge clk); evt_tx = 5'h02;
    @(negedge clk); evt_tx = '0;
    check("R7 not yet after one edge", {31'b0, irq_out}, 0);
    @(negedge clk);
    check("R7 rises second edge", {31'b0, irq_out}, 1);
    cycles(3);
    check("R7 holds while pending", {31'b0, irq_out}, 1);
    wr(8'h28, 32'h00000002);
    check("R7 still high at ack edge", {31'b0, irq_out}, 1);
    @(negedge clk);
    check("R7 drops next edge", {31'b0, irq_out}, 0);
    wr(8'h24, 32'h00000002);
    cycles(4);
    check("R8 no refire before EOI", {31'b0, irq_out}, 0);
    wr(8'h3C, 32'h12345678);
    check("R8 EOI edge", {31'b0, irq_out}, 0);
    @(negedge clk);
    check("R8 refire after EOI", {31'b0, irq_out}, 1);
    wr(8'h28, 32'hFFFFFFFF);
    wr(8'h3C, 32'h0);
    wr(8'h24, 32'h00000004);
    cycles(3);
    check("R6 unmasked source quiet", {31'b0, irq_out}, 0);
    clean();
  endtask

  task automatic t_soft();
    logic [31:0] v;
    wr(8'h2C, 32'h00000008);
    wr(8'h24, 32'h00000008);
    @(negedge clk);
    check("R9 fired before reset", {31'b0, irq_out}, 1);
    wr(8'h04, 32'hFFFFFFFE);
    rd(8'h20, v); check("R9 bit0 zero no effect", v, 32'h8);
    rd(8'h04, v); check("R9 ctrl reads zero", v, 0);
    wr(8'h04, 32'h00000001);
    check("R9 irq dropped", {31'b0, irq_out}, 0);
    rd(8'h20, v); check("R9 raw cleared", v, 0);
    rd(8'h2C, v); check("R9 mask cleared", v, 0);
    wr(8'h30, 32'h00010000);
    wr(8'h24, 32'h00010000);
    @(negedge clk);
    check("R9 rearmed", {31'b0, irq_out}, 1);
    rd(8'h40, v); check("R10 undefined offset", v, 0);
    rd(8'h24, v); check("R10 alias reads zero", v, 0);
    clean();
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(4);
    t_reset();
    t_mapping();
    t_set_clr();
    t_mask();
    t_irq();
    t_soft();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cycles(20000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule